// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block decides when the memory controller sends auto-refresh commands to a synchronous DRAM. A free-running interval timer raises one refresh demand every `INTERVAL` clock cycles. With the default parameters, 780 cycles at 100 MHz meets the rule that 8192 rows must all be refreshed within 64 ms. Demands are held as credits. While the access sequencer has work in flight, refresh can wait, so the gap between two commands may be longer than the nominal interval.

When the number of outstanding demands reaches `MAX_DEBT`, the block raises an urgent request and blocks new accesses. Once all banks are precharged, it sends the refresh even if accesses are still waiting. After each command, a busy window of `trfc_i` cycles keeps the array unavailable. The controller never sends a row address with a refresh command, because the device steps its own row counter. The block keeps a copy of that counter, so the controller always knows which row the next command will refresh.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst_ni` is low, the outputs read `ref_cmd_o`=0, `cmd_o`=3'b111, `busy_o`=0, `block_access_o`=0, `urgent_o`=0, `debt_o`=0 and `row_o`=0.
- R2: A demand is added once every `INTERVAL` cycles. The first one appears in `debt_o` `INTERVAL` cycles after reset is released.
- R3: `debt_o` never exceeds `MAX_DEBT`, and a demand that arrives at that level is dropped. `urgent_o` is high exactly when `debt_o` equals `MAX_DEBT`.
- R4: A command is issued in the cycle after an edge at which all of these held: `debt_o`>0, `busy_o` low, `banks_idle_i` high, and either `access_pend_i` low or `urgent_o` high. No command is issued otherwise.
- R5: `cmd_o` is ordered {row strobe, column strobe, write enable}, all active low. It reads 3'b001 in the cycle `ref_cmd_o` is high and 3'b111 (no operation) in every other cycle.
- R6: `busy_o` is high for `trfc_i` cycles, counting the command cycle, and `trfc_i`=0 counts as 1. No further command is issued while `busy_o` is high.
- R7: `block_access_o` is high whenever `busy_o` or `urgent_o` is high, and low otherwise.
- R8: `row_o` names the row the next command will refresh. It increments by one with each command and wraps from 2^`ROW_BITS`-1 to 0.
- R9: Each command takes one credit. If a new demand arrives in the same cycle, `debt_o` stays unchanged.
- R10: Under permanent access traffic, with banks idle at least once per interval and `trfc_i` shorter than the interval, every row is refreshed again within (2^`ROW_BITS`+`MAX_DEBT`+2)·`INTERVAL` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| banks_idle_i | input | 1 | All banks are precharged |
| access_pend_i | input | 1 | The access sequencer has accesses in progress or waiting |
| trfc_i | input | TRFC_W | Length of the busy window after a refresh, in cycles |
| ref_cmd_o | output | 1 | One-cycle pulse: a refresh command is on the bus |
| cmd_o | output | 3 | Command strobes {ras_n, cas_n, we_n} |
| busy_o | output | 1 | A refresh is in progress |
| block_access_o | output | 1 | The sequencer must not start a new access |
| urgent_o | output | 1 | The credit limit is reached and refresh takes priority |
| debt_o | output | $clog2(MAX_DEBT+1) | Outstanding refresh demands |
| row_o | output | ROW_BITS | Copy of the device's row counter |

## Verification
If the credit counter is off by one, `debt_o` differs from the bench model within a cycle. In the saturation scenario, `urgent_o` and `block_access_o` also rise at the wrong moment. A wrong busy count shows as a refresh pulse that comes early or late at the end of the window. A row copy that steps wrongly diverges at the next command and stays wrong until reset, so one cycle of comparison catches it. The heavy-traffic phase also measures, for each row, the time between its refreshes against the retention bound.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } dram_cmd_t;

  localparam dram_cmd_t CMD_NOP = 3'b111;
  localparam dram_cmd_t CMD_REF = 3'b001;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (INTERVAL < 2) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_count
      localparam int CNT_W = $clog2(INTERVAL);
      logic [CNT_W-1:0] cnt_q;

      assign tick_o = (cnt_q == CNT_W'(INTERVAL - 1));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + CNT_W'(1);
      end

      p_tick_spaced_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/ref_credit_ctr.sv
module ref_credit_ctr #(
  parameter int MAX_DEBT = 8,
  localparam int DEBT_W = $clog2(MAX_DEBT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              take_i,
  output logic [DEBT_W-1:0] debt_o,
  output logic              full_o
);
  logic [DEBT_W-1:0] debt_q;

  assign debt_o = debt_q;
  assign full_o = (debt_q == DEBT_W'(MAX_DEBT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      debt_q <= '0;
    end else begin
      unique case ({tick_i, take_i})
        2'b10:   if (!full_o) debt_q <= debt_q + DEBT_W'(1);
        2'b01:   debt_q <= debt_q - DEBT_W'(1);
        default: debt_q <= debt_q;
      endcase
    end
  end

  p_debt_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debt_q <= DEBT_W'(MAX_DEBT));
  p_take_has_credit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> debt_q != '0);
  p_take_decr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !tick_i) |=> debt_q == $past(debt_q) - DEBT_W'(1));
  p_take_tick_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && tick_i) |=> $stable(debt_q));
endmodule

// File: rtl/ref_busy_timer.sv
module ref_busy_timer #(
  parameter int TRFC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TRFC_W-1:0] trfc_i,
  output logic              busy_o
);
  logic [TRFC_W-1:0] left_q;
  logic [TRFC_W-1:0] load;

  // a zero window still covers the command cycle
  assign load   = (trfc_i == '0) ? TRFC_W'(1) : trfc_i;
  assign busy_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      left_q <= '0;
    else if (start_i) left_q <= load;
    else if (busy_o)  left_q <= left_q - TRFC_W'(1);
  end

  p_start_when_free_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  p_start_sets_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
endmodule

// File: rtl/ref_row_mirror.sv
module ref_row_mirror #(
  parameter int ROW_BITS = 13
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  output logic [ROW_BITS-1:0] row_o
);
  logic [ROW_BITS-1:0] row_q;

  assign row_o = row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (step_i) row_q <= row_q + ROW_BITS'(1);
  end

  p_row_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> row_q == $past(row_q) + ROW_BITS'(1));
  p_row_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(row_q));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int INTERVAL = 780,
  parameter int MAX_DEBT = 8,
  parameter int ROW_BITS = 13,
  parameter int TRFC_W   = 8,
  localparam int DEBT_W  = $clog2(MAX_DEBT + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                banks_idle_i,
  input  logic                access_pend_i,
  input  logic [TRFC_W-1:0]   trfc_i,
  output logic                ref_cmd_o,
  output logic [2:0]          cmd_o,
  output logic                busy_o,
  output logic                block_access_o,
  output logic                urgent_o,
  output logic [DEBT_W-1:0]   debt_o,
  output logic [ROW_BITS-1:0] row_o
);
  logic      tick;
  logic      issue;
  logic      busy;
  logic      full;
  logic      ref_q;
  dram_cmd_t cmd;

  ref_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  ref_credit_ctr #(.MAX_DEBT(MAX_DEBT)) u_credit (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .take_i(issue),
    .debt_o(debt_o),
    .full_o(full)
  );

  ref_busy_timer #(.TRFC_W(TRFC_W)) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(issue),
    .trfc_i (trfc_i),
    .busy_o (busy)
  );

  ref_row_mirror #(.ROW_BITS(ROW_BITS)) u_row (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(issue),
    .row_o (row_o)
  );

  // urgent credit overrides pending accesses, never open banks
  assign issue = (debt_o != '0) && !busy && banks_idle_i && (!access_pend_i || full);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= 1'b0;
    else         ref_q <= issue;
  end

  assign cmd            = ref_q ? CMD_REF : CMD_NOP;
  assign cmd_o          = cmd;
  assign ref_cmd_o      = ref_q;
  assign busy_o         = busy;
  assign urgent_o       = full;
  assign block_access_o = busy | full;

  p_cmd_needs_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cmd_o |-> $past(banks_idle_i));
  p_cmd_strobes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cmd_o |-> (cmd_o == 3'b001));
  p_nop_strobes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_cmd_o |-> (cmd_o == 3'b111));
  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cmd_o |=> !ref_cmd_o);
  p_cmd_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cmd_o |-> busy_o);
  p_urgent_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urgent_o |-> block_access_o);
  p_urgent_served_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (urgent_o && banks_idle_i && !busy_o) |=> ref_cmd_o);
endmodule

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int INTERVAL   = 16;
  localparam int MAX_DEBT   = 8;
  localparam int ROW_BITS   = 5;
  localparam int TRFC_W     = 8;
  localparam int DEBT_W     = $clog2(MAX_DEBT + 1);
  localparam int ROWS       = 1 << ROW_BITS;
  localparam int WINDOW     = (ROWS + MAX_DEBT + 2) * INTERVAL;

  logic clk = 1'b0;
  logic rst_ni;
  logic banks_idle, access_pend;
  logic [TRFC_W-1:0] trfc;
  logic ref_cmd, busy, block_acc, urgent;
  logic [2:0] cmd;
  logic [DEBT_W-1:0] debt;
  logic [ROW_BITS-1:0] row;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dram_refresh_sched #(
    .INTERVAL(INTERVAL), .MAX_DEBT(MAX_DEBT), .ROW_BITS(ROW_BITS), .TRFC_W(TRFC_W)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .banks_idle_i(banks_idle), .access_pend_i(access_pend),
    .trfc_i(trfc), .ref_cmd_o(ref_cmd), .cmd_o(cmd), .busy_o(busy),
    .block_access_o(block_acc), .urgent_o(urgent), .debt_o(debt), .row_o(row)
  );

  int n_vec = 0, n_bad = 0;
  int m_cnt, m_debt, m_bcnt, m_row, m_ref;
  int cyc = 0;
  bit track = 0;
  int last_ref[ROWS];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit bi, bit ap, int tr);
    bit urg, iss, tk;
    banks_idle  = bi;
    access_pend = ap;
    trfc        = TRFC_W'(tr);
    urg = (m_debt == MAX_DEBT);
    iss = (m_debt > 0) && (m_bcnt == 0) && bi && (!ap || urg);
    tk  = (m_cnt == INTERVAL - 1);
    @(posedge clk);
    m_cnt = tk ? 0 : m_cnt + 1;
    if (tk && !iss)      m_debt = (m_debt < MAX_DEBT) ? m_debt + 1 : m_debt;
    else if (!tk && iss) m_debt = m_debt - 1;
    if (iss) begin
      if (track) begin
        // R10: per-row refresh gap
        chk(cyc + 1 - last_ref[m_row] <= WINDOW, "R10", "row refresh gap",
            cyc + 1 - last_ref[m_row], WINDOW);
        last_ref[m_row] = cyc + 1;
      end
      m_bcnt = (tr == 0) ? 1 : tr;
      m_row  = (m_row + 1) % ROWS;
    end else if (m_bcnt > 0) begin
      m_bcnt = m_bcnt - 1;
    end
    m_ref = iss;
    @(negedge clk);
    cyc++;
    chk(int'(ref_cmd) == m_ref, "R4", "ref_cmd_o", int'(ref_cmd), m_ref);
    chk(int'(cmd) == (m_ref ? 1 : 7), "R5", "cmd_o", int'(cmd), m_ref ? 1 : 7);
    chk(int'(debt) == m_debt, iss ? "R9" : "R2", "debt_o", int'(debt), m_debt);
    chk(int'(urgent) == int'(m_debt == MAX_DEBT), "R3", "urgent_o", int'(urgent),
        int'(m_debt == MAX_DEBT));
    chk(int'(busy) == int'(m_bcnt != 0), "R6", "busy_o", int'(busy), int'(m_bcnt != 0));
    chk(int'(block_acc) == int'(m_bcnt != 0 || m_debt == MAX_DEBT), "R7", "block_access_o",
        int'(block_acc), int'(m_bcnt != 0 || m_debt == MAX_DEBT));
    chk(int'(row) == m_row, "R8", "row_o", int'(row), m_row);
  endtask

  function automatic bit rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL R1 watchdog: actual %0d cycles expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; banks_idle = 1'b1; access_pend = 1'b0; trfc = '0;
    m_cnt = 0; m_debt = 0; m_bcnt = 0; m_row = 0; m_ref = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(ref_cmd == 1'b0, "R1", "ref_cmd_o", int'(ref_cmd), 0);
    chk(cmd == 3'b111, "R1", "cmd_o", int'(cmd), 7);
    chk(busy == 1'b0 && block_acc == 1'b0 && urgent == 1'b0, "R1", "busy/block/urgent",
        int'({busy, block_acc, urgent}), 0);
    chk(debt == '0, "R1", "debt_o", int'(debt), 0);
    chk(row == '0, "R1", "row_o", int'(row), 0);
    rst_ni = 1'b1;

    // R2: first demand after INTERVAL cycles, banks not yet idle
    for (int i = 0; i < 20; i++) step(0, 0, 3);
    // idle controller: refresh as soon as a credit exists
    for (int i = 0; i < 100; i++) step(1, 0, 3);
    // R4: access traffic postpones until the credit limit (R3)
    for (int i = 0; i < 200; i++) step(1, 1, 4);
    // R3: saturation while banks stay open, then release
    for (int i = 0; i < 250; i++) step(0, 1, 4);
    for (int i = 0; i < 100; i++) step(1, 1, 4);
    // drain the backlog, back-to-back windows; R6 with trfc 0 and 1
    for (int i = 0; i < 60; i++) step(1, 0, 0);
    for (int i = 0; i < 150; i++) step(0, 1, 1);
    for (int i = 0; i < 60; i++) step(1, 0, 1);
    // mixed traffic, long windows
    for (int i = 0; i < 800; i++) step(rnd(), rnd(), 10);
    // R10: heavy traffic with row wrap (R8)
    for (int r = 0; r < ROWS; r++) last_ref[r] = cyc;
    track = 1;
    for (int i = 0; i < 3000; i++) step(rnd() | rnd(), 1, 5);
    track = 0;
    for (int r = 0; r < ROWS; r++)
      chk(cyc - last_ref[r] <= WINDOW, "R10", "final row age", cyc - last_ref[r], WINDOW);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule